// File: doc/BRIEF.md
# Received Signal Quality Meter

This block grades the timing of a received data stream. For every received bit the demodulator supplies a strobe and the size of the gap between the detected zero crossing and the locally generated expected crossing. A bit whose gap is within a fixed tolerance counts as good. After a fixed window of bits the number of good bits is stored in an 8-bit quality register, and a one-cycle completion strobe goes to the status logic.

The receive task sequencer restarts the window when a block-oriented receive task finishes. This keeps the next result aligned to data blocks. When either the envelope or the end-of-packet detector is enabled in receive mode, the two low register bits show the detector outputs instead of the quality count. In transmit mode the whole register reads as zero. In power-save mode the count is shown unaltered.

Top module: `sigq_meter`

## Requirements
- R1: While reset is low and on the first cycle after it, `qual_out` is 0 and `done_stb` is 0.
- R2: A bit is good when `zc_err` is less than or equal to the tolerance (default 8) and bad otherwise. The stored result is the number of good bits in the window of 240 bit strobes, so it lies in 0..240.
- R3: The result appears on `qual_out` in the clock cycle after the edge that samples the 240th bit strobe. `done_stb` is high in that same cycle only and is low otherwise.
- R4: The stored result holds until the next window completes.
- R5: A `restart_stb` discards the partial count, and the next window starts from zero bits.
- R6: A `restart_stb` sampled on the same edge as the 240th bit strobe wins. No completion strobe is raised and the stored result is not changed.
- R7: In receive mode (`tx_mode` and `psave_mode` low), if `env_en` or `eop_en` is 1, bit 0 of `qual_out` is `env_det` and bit 1 is `eop_det`. Bits 7..2 stay the stored result.
- R8: When `psave_mode` is high, the detector override is off and `qual_out` is the stored result.
- R9: When `tx_mode` is high, `qual_out` is 0.
- R10: While `tx_mode` or `psave_mode` is high, bit strobes are not counted and the partial window is cleared.
- R11: `rd_stb` changes neither `qual_out` nor the count in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per received bit |
| zc_err | input | 6 | Magnitude of the zero-crossing timing error for this bit |
| restart_stb | input | 1 | Restarts the measurement window |
| env_det | input | 1 | Envelope detector output |
| eop_det | input | 1 | End-of-packet detector output |
| env_en | input | 1 | Envelope detector enable |
| eop_en | input | 1 | End-of-packet detector enable |
| tx_mode | input | 1 | Transmit mode |
| psave_mode | input | 1 | Power-save mode |
| rd_stb | input | 1 | Register read strobe |
| qual_out | output | 8 | Quality register value |
| done_stb | output | 1 | One-cycle measurement-complete strobe |

## Verification
The result and `done_stb` come from one register stage. Both are due in the cycle after the rising edge that samples the final bit strobe, and the bench reads them at the falling edge that ends that cycle. The detector override and the transmit zeroing are combinational on the stored value, so their checks read `qual_out` at the falling edge after the mode or detector inputs change. All inputs change on falling edges, so each sample falls half a period away from any edge where the design acts.

// File: rtl/sigq_pkg.sv
// Shared parameters and helpers for the signal quality meter.
// Assumes the window length fits in the count width.
package sigq_pkg;
    localparam int unsigned SQ_WIN   = 240;
    localparam int unsigned SQ_CNT_W = 8;
    localparam int unsigned SQ_ERR_W = 6;
    localparam int unsigned SQ_TOL   = 8;

    // Returns 1 when an error magnitude is within tolerance.
    function automatic logic within_tol(input logic [SQ_ERR_W-1:0] err,
                                        input logic [SQ_ERR_W-1:0] tol);
        return (err <= tol);
    endfunction
endpackage

// File: rtl/sigq_accum.sv
// Counts good bits over a fixed window and latches the total at window end.
// Assumes bit_stb is a single-cycle pulse. A restart or hold clears the window.
module sigq_accum
    import sigq_pkg::*;
#(
    parameter int unsigned WIN   = SQ_WIN,
    parameter int unsigned CNT_W = SQ_CNT_W,
    parameter int unsigned ERR_W = SQ_ERR_W,
    parameter int unsigned TOL   = SQ_TOL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic [ERR_W-1:0] zc_err,
    input  logic             restart_stb,
    input  logic             hold,
    output logic [CNT_W-1:0] result,
    output logic             done_stb
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WIN - 1);
    localparam logic [ERR_W-1:0] TOL_V    = ERR_W'(TOL);

    logic [CNT_W-1:0] bit_pos;
    logic [CNT_W-1:0] good_cnt;
    logic             good;

    // Classify the current bit against the tolerance.
    always_comb good = (ERR_W == SQ_ERR_W) ? within_tol(zc_err, TOL_V) : (zc_err <= TOL_V);

    // Advance the window, latch the total and pulse completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pos  <= '0;
            good_cnt <= '0;
            result   <= '0;
            done_stb <= 1'b0;
        end else if (restart_stb || hold) begin
            bit_pos  <= '0;
            good_cnt <= '0;
            done_stb <= 1'b0;
        end else if (bit_stb) begin
            if (bit_pos == LAST_POS) begin
                result   <= good_cnt + CNT_W'(good);
                done_stb <= 1'b1;
                bit_pos  <= '0;
                good_cnt <= '0;
            end else begin
                bit_pos  <= bit_pos + 1'b1;
                good_cnt <= good_cnt + CNT_W'(good);
                done_stb <= 1'b0;
            end
        end else begin
            done_stb <= 1'b0;
        end
    end
endmodule

// File: rtl/sigq_view.sv
// Forms the visible register value from the stored count and the mode inputs.
// Purely combinational. Transmit mode zeroes the value. In receive mode an
// enabled detector replaces the two low bits.
module sigq_view #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] result,
    input  logic             env_det,
    input  logic             eop_det,
    input  logic             env_en,
    input  logic             eop_en,
    input  logic             tx_mode,
    input  logic             psave_mode,
    output logic [CNT_W-1:0] view
);
    logic ovr;

    // Select between count, detector override and transmit zero.
    always_comb begin
        ovr  = (env_en || eop_en) && !psave_mode;
        view = result;
        if (ovr) begin
            view[0] = env_det;
            view[1] = eop_det;
        end
        if (tx_mode) view = '0;
    end
endmodule

// File: rtl/sigq_meter.sv
// Top of the received signal quality meter. It joins the window counter and
// the output view, and holds counting off in transmit and power-save modes.
// The read strobe is accepted for interface completeness and has no side effect.
module sigq_meter
    import sigq_pkg::*;
#(
    parameter int unsigned WIN   = SQ_WIN,
    parameter int unsigned CNT_W = SQ_CNT_W,
    parameter int unsigned ERR_W = SQ_ERR_W,
    parameter int unsigned TOL   = SQ_TOL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic [ERR_W-1:0] zc_err,
    input  logic             restart_stb,
    input  logic             env_det,
    input  logic             eop_det,
    input  logic             env_en,
    input  logic             eop_en,
    input  logic             tx_mode,
    input  logic             psave_mode,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] qual_out,
    output logic             done_stb
);
    logic             hold;
    logic [CNT_W-1:0] result;
    logic             rd_unused;

    // Counting runs only in receive mode.
    always_comb hold = tx_mode || psave_mode;
    // Reads are non-destructive for the register value.
    always_comb rd_unused = rd_stb;

    sigq_accum #(.WIN(WIN), .CNT_W(CNT_W), .ERR_W(ERR_W), .TOL(TOL)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .zc_err      (zc_err),
        .restart_stb (restart_stb),
        .hold        (hold),
        .result      (result),
        .done_stb    (done_stb)
    );

    sigq_view #(.CNT_W(CNT_W)) u_view (
        .result     (result),
        .env_det    (env_det),
        .eop_det    (eop_det),
        .env_en     (env_en),
        .eop_en     (eop_en),
        .tx_mode    (tx_mode),
        .psave_mode (psave_mode),
        .view       (qual_out)
    );
endmodule

// File: rtl/sigq_meter_chk.sv
// Property checker for sigq_meter, bound to every instance of it.
module sigq_meter_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned WIN   = 240
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_stb,
    input logic             restart_stb,
    input logic             tx_mode,
    input logic             psave_mode,
    input logic [CNT_W-1:0] qual_out,
    input logic             done_stb
);
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> !done_stb);

    assert_done_after_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |-> $past(bit_stb));

    assert_restart_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_stb |=> !done_stb);

    assert_tx_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode |-> (qual_out == '0));

    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_mode && psave_mode) |-> (qual_out <= CNT_W'(WIN)));

    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_stb && !tx_mode && $past(!tx_mode)) |-> (qual_out[CNT_W-1:2] == $past(qual_out[CNT_W-1:2])));

    assert_hold_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode || psave_mode) |=> !done_stb);
endmodule

bind sigq_meter sigq_meter_chk #(.CNT_W(CNT_W), .WIN(WIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .restart_stb (restart_stb),
    .tx_mode     (tx_mode),
    .psave_mode  (psave_mode),
    .qual_out    (qual_out),
    .done_stb    (done_stb)
);

// File: tb/test_sigq_meter.sv
module test_sigq_meter;
    localparam int WIN = 240;
    localparam int TOL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic [5:0] zc_err = '0;
    logic       restart_stb = 1'b0;
    logic       env_det = 1'b0, eop_det = 1'b0, env_en = 1'b0, eop_en = 1'b0;
    logic       tx_mode = 1'b0, psave_mode = 1'b0, rd_stb = 1'b0;
    logic [7:0] qual_out;
    logic       done_stb;

    int total = 0;
    int bad = 0;
    int done_seen = 0;
    logic last_done;

    always #2.5 clk = ~clk;

    sigq_meter i_sigq_meter (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .zc_err(zc_err),
        .restart_stb(restart_stb), .env_det(env_det), .eop_det(eop_det),
        .env_en(env_en), .eop_en(eop_en), .tx_mode(tx_mode),
        .psave_mode(psave_mode), .rd_stb(rd_stb),
        .qual_out(qual_out), .done_stb(done_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bit; last_done is done_stb in the cycle after the bit is sampled.
    task automatic send_bit(input int err);
        @(negedge clk);
        bit_stb = 1'b1;
        zc_err  = 6'(err);
        @(negedge clk);
        bit_stb = 1'b0;
        last_done = done_stb;
        if (done_stb) done_seen++;
    endtask

    // Window of WIN bits, the first n_good good, the rest bad.
    task automatic send_window(input int n_good);
        for (int i = 0; i < WIN; i++) send_bit(i < n_good ? 0 : TOL + 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 qual in reset", qual_out, 0);
        chk("R1 done in reset", done_stb, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 qual after reset", qual_out, 0);
    endtask

    task automatic t_full_good;
        done_seen = 0;
        send_window(WIN);
        chk("R3 done on last bit", last_done, 1);
        chk("R2 all good = 240", qual_out, 240);
        @(negedge clk);
        chk("R3 done one cycle", done_stb, 0);
        chk("R3 single done", done_seen, 1);
    endtask

    task automatic t_pattern;
        for (int i = 0; i < WIN; i++) send_bit((i % 3 == 2) ? 20 : 3);
        chk("R2 two of three good", qual_out, 160);
        for (int i = 0; i < WIN; i++) send_bit((i % 2 == 0) ? TOL : TOL + 1);
        chk("R2 tolerance edge", qual_out, 120);
        send_window(0);
        chk("R2 all bad", qual_out, 0);
    endtask

    task automatic t_hold;
        send_window(77);
        for (int i = 0; i < 100; i++) send_bit(0);
        chk("R4 held mid window", qual_out, 77);
        chk("R3 no done mid window", last_done, 0);
        @(negedge clk); restart_stb = 1'b1;
        @(negedge clk); restart_stb = 1'b0;
    endtask

    task automatic t_restart_mid;
        for (int i = 0; i < 100; i++) send_bit(0);
        @(negedge clk); restart_stb = 1'b1;
        @(negedge clk); restart_stb = 1'b0;
        send_window(50);
        chk("R5 partial discarded", qual_out, 50);
    endtask

    task automatic t_restart_last;
        for (int i = 0; i < WIN - 1; i++) send_bit(0);
        @(negedge clk);
        bit_stb = 1'b1; zc_err = '0; restart_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; restart_stb = 1'b0;
        chk("R6 no done on clash", done_stb, 0);
        chk("R6 result kept", qual_out, 50);
        send_window(10);
        chk("R6 fresh window", qual_out, 10);
    endtask

    task automatic t_override;
        send_window(163);
        chk("R2 163 good", qual_out, 163);
        @(negedge clk); env_en = 1'b1; env_det = 1'b0; eop_det = 1'b0;
        @(negedge clk);
        chk("R7 low bits from detectors 00", qual_out, 160);
        env_en = 1'b0; eop_en = 1'b1; env_det = 1'b0; eop_det = 1'b1;
        @(negedge clk);
        chk("R7 eop on bit1", qual_out, 162);
        psave_mode = 1'b1;
        @(negedge clk);
        chk("R8 psave shows count", qual_out, 163);
        psave_mode = 1'b0; tx_mode = 1'b1;
        @(negedge clk);
        chk("R9 tx zero", qual_out, 0);
        tx_mode = 1'b0; eop_en = 1'b0; eop_det = 1'b0;
        @(negedge clk);
        chk("R9 count back after tx", qual_out, 163);
    endtask

    task automatic t_mode_hold;
        for (int i = 0; i < 100; i++) send_bit(0);
        @(negedge clk); tx_mode = 1'b1;
        for (int i = 0; i < 200; i++) send_bit(0);
        chk("R10 tx no done", last_done, 0);
        @(negedge clk); tx_mode = 1'b0; psave_mode = 1'b1;
        for (int i = 0; i < 200; i++) send_bit(0);
        @(negedge clk); psave_mode = 1'b0;
        for (int i = 0; i < 140; i++) send_bit(0);
        chk("R10 partial cleared", last_done, 0);
        chk("R10 result kept", qual_out, 163);
        for (int i = 0; i < 100; i++) send_bit(TOL + 1);
        chk("R10 window ends at 240", last_done, 1);
        chk("R10 count after modes", qual_out, 140);
    endtask

    task automatic t_read;
        for (int i = 0; i < 30; i++) send_bit(0);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        chk("R11 read keeps value", qual_out, 140);
        chk("R11 read no done", done_stb, 0);
        for (int i = 0; i < WIN - 30; i++) send_bit(TOL + 1);
        chk("R11 count unaffected", qual_out, 30);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_full_good();
        t_pattern();
        t_hold();
        t_restart_mid();
        t_restart_last();
        t_override();
        t_mode_hold();
        t_read();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule